// File: doc/BRIEF.md
# I2C Random-Read Sequencer

This block drives a register-mapped, byte-level I2C master engine through a complete random read from a memory-style target. A single start request supplies a 7-bit target address, a one- or two-byte internal offset and a byte count. The sequencer first initialises the engine. It then writes the offset, issues a repeated start and switches the bus direction to read. It clocks in the requested bytes, acknowledging every byte except the final one, and finishes with a stop.

Each engine command is a one-cycle write strobe that carries a register selector and a data byte. After every bus step the sequencer polls the engine status byte once per gap interval, for a bounded number of polls. Each step has exactly one expected status code. If any step misses its code within the budget, the transfer aborts and the last status seen is reported. Received bytes leave the block in order, each with a one-cycle valid strobe. A finished transfer raises a one-cycle done pulse.

State machine: `IDLE` waits for a request. `INIT_RST`, `INIT_CLR0`, `INIT_CLR1` and `INIT_BAUD` each issue one set-up write. `LOAD_DATA` writes the byte register when a step carries a byte. `ISSUE_CTRL` writes the control register. `POLL` samples the status.

The bus steps, in transition order, are:
- `ENA` (enable)
- `STA` (start)
- `ADW` (address for write)
- `OFH` (high offset byte, wide offsets only)
- `OFL` (low offset byte)
- `RSTA` (repeated start)
- `ADR` (address for read)
- `RDA` (acknowledged read, repeated count-1 times)
- `RDN` (final read with no acknowledge)
- `STP` (stop)

A status hit in `POLL` advances to the next step, going through `LOAD_DATA` or straight to `ISSUE_CTRL`. A hit on `STP` returns to `IDLE` with done. Running out of the poll budget returns to `IDLE` with an error.

Top module: `i2c_rand_read_seq`

## Requirements
- R1: After a valid request, the first four engine writes are: selector 0 (engine reset), selector 1 (own address), selector 2 (extended own address), each with data 0x00, then selector 3 (bus clock divider) with data BAUD_VAL. Selector 4 is the control register and selector 5 the byte register.
- R2: The enable step writes control 0x40 and expects status 0xF8. The start step writes 0x60 and expects 0x08. The write-address step writes byte {addr,0} followed by control 0x40, and expects 0x18.
- R3: With `ofs_wide`=1 the offset high byte is sent before the low byte. With `ofs_wide`=0 only the low byte is sent. Each offset byte uses control 0x40 and expects 0x28.
- R4: The repeated start writes control 0x60 and expects 0x10. The byte {addr,1} then goes out with control 0x40 and expects 0x40.
- R5: The first count-1 reads use control 0x44 and expect 0x50. The last read uses control 0x40 and expects 0x58. A stop then writes control 0x50 and expects 0xF8, after which `done` pulses for one cycle with `busy` low.
- R6: Each byte read is presented on `rx_data` with `rx_valid` high for exactly one cycle, in bus order, and exactly count strobes occur per successful transfer.
- R7: Status is sampled once every GAP_CYCLES cycles, and each step gets at most POLL_LIMIT samples. When no sample matches, the transfer aborts.
- R8: On abort, `err` pulses for one cycle with `busy` low. `err_code` holds the last sampled status until the next error, and no further bytes or writes follow.
- R9: A request with count 0 raises `err` with `err_code` 0xFF in the next cycle and makes no engine write.
- R10: `start` is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `err`, `rx_valid` and `reg_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, sampled in idle |
| tgt_addr | input | 7 | Target 7-bit address |
| ofs | input | 16 | Internal offset |
| ofs_wide | input | 1 | 1: two offset bytes, 0: one |
| count | input | CNT_W | Number of bytes to read |
| eng_status | input | 8 | Engine status byte |
| eng_rdata | input | 8 | Engine received byte |
| reg_wr | output | 1 | Engine register write strobe |
| reg_sel | output | 3 | Engine register selector |
| reg_wdata | output | 8 | Engine register write data |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle abort pulse |
| err_code | output | 8 | Status behind the last error |

## Verification
The assertions assume that `start` is held for a single cycle. They also assume that the engine status and read data stay steady around the sampling edge. The engine model in the bench meets both conditions: it changes status and read data only on falling edges and answers each command within fewer cycles than one poll gap. That reply latency also keeps any poll from seeing a stale status from the step before. Faults are injected through the model alone, either by refusing the target address or by staying silent after an offset byte, so every error path follows the same assumptions.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [2:0] {
        IDLE, INIT_RST, INIT_CLR0, INIT_CLR1, INIT_BAUD, LOAD_DATA, ISSUE_CTRL, POLL
    } state_t;

    typedef enum logic [3:0] {
        ST_ENA, ST_STA, ST_ADW, ST_OFH, ST_OFL, ST_RSTA, ST_ADR, ST_RDA, ST_RDN, ST_STP
    } step_t;

    localparam logic [2:0] SEL_RESET = 3'd0;
    localparam logic [2:0] SEL_OWN   = 3'd1;
    localparam logic [2:0] SEL_OWNX  = 3'd2;
    localparam logic [2:0] SEL_BAUD  = 3'd3;
    localparam logic [2:0] SEL_CTRL  = 3'd4;
    localparam logic [2:0] SEL_DATA  = 3'd5;

    localparam logic [7:0] C_EN    = 8'h40;
    localparam logic [7:0] C_START = 8'h20;
    localparam logic [7:0] C_STOP  = 8'h10;
    localparam logic [7:0] C_ACK   = 8'h04;

    localparam logic [7:0] S_IDLE     = 8'hF8;
    localparam logic [7:0] S_START    = 8'h08;
    localparam logic [7:0] S_RESTART  = 8'h10;
    localparam logic [7:0] S_AW_ACK   = 8'h18;
    localparam logic [7:0] S_WB_ACK   = 8'h28;
    localparam logic [7:0] S_AR_ACK   = 8'h40;
    localparam logic [7:0] S_RD_ACK   = 8'h50;
    localparam logic [7:0] S_RD_NACK  = 8'h58;
    localparam logic [7:0] ZERO_CODE  = 8'hFF;

endpackage

// File: rtl/rrs_poll_timer.sv
module rrs_poll_timer #(
    parameter int GAP_CYCLES = 10,
    parameter int POLL_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic run,
    output logic smp,
    output logic last
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam int TW = $clog2(POLL_LIMIT + 1);

    logic [GW-1:0] gap_q;
    logic [TW-1:0] tries_q;

    assign smp  = run && (gap_q == GW'(GAP_CYCLES - 1));
    assign last = (tries_q == TW'(POLL_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            tries_q <= '0;
        end else if (arm) begin
            gap_q   <= '0;
            tries_q <= '0;
        end else if (smp) begin
            gap_q   <= '0;
            tries_q <= tries_q + 1'b1;
        end else if (run) begin
            gap_q   <= gap_q + 1'b1;
        end
    end
endmodule

// File: rtl/rrs_read_counter.sv
module rrs_read_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] rem
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rem <= '0;
        else if (load) rem <= load_val;
        else if (dec)  rem <= rem - 1'b1;
    end
endmodule

// File: rtl/i2c_rand_read_seq.sv
module i2c_rand_read_seq
    import rrs_pkg::*;
#(
    parameter int         GAP_CYCLES = 10,
    parameter int         POLL_LIMIT = 1000,
    parameter int         CNT_W      = 8,
    parameter logic [7:0] BAUD_VAL   = 8'h24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [6:0]       tgt_addr,
    input  logic [15:0]      ofs,
    input  logic             ofs_wide,
    input  logic [CNT_W-1:0] count,
    input  logic [7:0]       eng_status,
    input  logic [7:0]       eng_rdata,
    output logic             reg_wr,
    output logic [2:0]       reg_sel,
    output logic [7:0]       reg_wdata,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [7:0]       err_code
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    state_t           state;
    step_t            step, nxt_step;
    logic [6:0]       addr_q;
    logic [15:0]      ofs_q;
    logic             wide_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rem;
    logic [7:0]       want, ctrl_val, data_val;
    logic             smp, last, hit, accept;

    assign busy   = (state != IDLE);
    assign accept = (state == IDLE) && start && (count != '0);
    assign hit    = (eng_status == want);

    rrs_poll_timer #(.GAP_CYCLES(GAP_CYCLES), .POLL_LIMIT(POLL_LIMIT)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (state == ISSUE_CTRL),
        .run  (state == POLL),
        .smp  (smp),
        .last (last)
    );

    rrs_read_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state == POLL && smp && hit && step == ST_ADR),
        .load_val(cnt_q - ONE),
        .dec     (state == POLL && smp && hit && step == ST_RDA),
        .rem     (rem)
    );

    function automatic logic carries_byte(step_t s);
        return (s == ST_ADW) || (s == ST_OFH) || (s == ST_OFL) || (s == ST_ADR);
    endfunction

    always_comb begin
        want     = S_IDLE;
        ctrl_val = C_EN;
        data_val = 8'h00;
        nxt_step = ST_STP;
        unique case (step)
            ST_ENA:  begin want = S_IDLE;    nxt_step = ST_STA; end
            ST_STA:  begin want = S_START;   ctrl_val = C_EN | C_START; nxt_step = ST_ADW; end
            ST_ADW:  begin want = S_AW_ACK;  data_val = {addr_q, 1'b0};
                           nxt_step = wide_q ? ST_OFH : ST_OFL; end
            ST_OFH:  begin want = S_WB_ACK;  data_val = ofs_q[15:8]; nxt_step = ST_OFL; end
            ST_OFL:  begin want = S_WB_ACK;  data_val = ofs_q[7:0];  nxt_step = ST_RSTA; end
            ST_RSTA: begin want = S_RESTART; ctrl_val = C_EN | C_START; nxt_step = ST_ADR; end
            ST_ADR:  begin want = S_AR_ACK;  data_val = {addr_q, 1'b1};
                           nxt_step = (cnt_q == ONE) ? ST_RDN : ST_RDA; end
            ST_RDA:  begin want = S_RD_ACK;  ctrl_val = C_EN | C_ACK;
                           nxt_step = (rem == ONE) ? ST_RDN : ST_RDA; end
            ST_RDN:  begin want = S_RD_NACK; nxt_step = ST_STP; end
            ST_STP:  begin want = S_IDLE;    ctrl_val = C_EN | C_STOP; nxt_step = ST_STP; end
            default: begin want = S_IDLE;    nxt_step = ST_STP; end
        endcase
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= IDLE;
            step   <= ST_ENA;
            addr_q <= '0;
            ofs_q  <= '0;
            wide_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            unique case (state)
                IDLE: if (accept) begin
                    addr_q <= tgt_addr;
                    ofs_q  <= ofs;
                    wide_q <= ofs_wide;
                    cnt_q  <= count;
                    step   <= ST_ENA;
                    state  <= INIT_RST;
                end
                INIT_RST:   state <= INIT_CLR0;
                INIT_CLR0:  state <= INIT_CLR1;
                INIT_CLR1:  state <= INIT_BAUD;
                INIT_BAUD:  state <= ISSUE_CTRL;
                LOAD_DATA:  state <= ISSUE_CTRL;
                ISSUE_CTRL: state <= POLL;
                POLL: if (smp) begin
                    if (hit) begin
                        if (step == ST_STP) begin
                            state <= IDLE;
                        end else begin
                            step  <= nxt_step;
                            state <= carries_byte(nxt_step) ? LOAD_DATA : ISSUE_CTRL;
                        end
                    end else if (last) begin
                        state <= IDLE;
                    end
                end
                default: state <= IDLE;
            endcase
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_wr    <= 1'b0;
            reg_sel   <= SEL_RESET;
            reg_wdata <= 8'h00;
            rx_data   <= 8'h00;
            rx_valid  <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            err_code  <= 8'h00;
        end else begin
            reg_wr   <= 1'b0;
            rx_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            unique case (state)
                IDLE: if (start && count == '0) begin
                    err      <= 1'b1;
                    err_code <= ZERO_CODE;
                end
                INIT_RST:   begin reg_wr <= 1'b1; reg_sel <= SEL_RESET; reg_wdata <= 8'h00; end
                INIT_CLR0:  begin reg_wr <= 1'b1; reg_sel <= SEL_OWN;   reg_wdata <= 8'h00; end
                INIT_CLR1:  begin reg_wr <= 1'b1; reg_sel <= SEL_OWNX;  reg_wdata <= 8'h00; end
                INIT_BAUD:  begin reg_wr <= 1'b1; reg_sel <= SEL_BAUD;  reg_wdata <= BAUD_VAL; end
                LOAD_DATA:  begin reg_wr <= 1'b1; reg_sel <= SEL_DATA;  reg_wdata <= data_val; end
                ISSUE_CTRL: begin reg_wr <= 1'b1; reg_sel <= SEL_CTRL;  reg_wdata <= ctrl_val; end
                POLL: if (smp) begin
                    if (hit) begin
                        if (step == ST_RDA || step == ST_RDN) begin
                            rx_valid <= 1'b1;
                            rx_data  <= eng_rdata;
                        end
                        if (step == ST_STP) done <= 1'b1;
                    end else if (last) begin
                        err      <= 1'b1;
                        err_code <= eng_status;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       reg_wr,
    input logic       rx_valid,
    input logic       done,
    input logic       err,
    input logic [7:0] err_code
);
    AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);               // R5
    AST_RX_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);       // R6
    AST_RX_IN_XFER:   assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> $past(busy));     // R6
    AST_ERR_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) err |-> !busy);                // R8
    AST_CODE_ON_ERR:  assert property (@(posedge clk) disable iff (!rst_n) !$stable(err_code) |-> err);   // R8
    AST_NO_DONE_ERR:  assert property (@(posedge clk) disable iff (!rst_n) !(done && err));               // R8
    AST_WR_IN_XFER:   assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> $past(busy));       // R9
endmodule

bind i2c_rand_read_seq rrs_checker i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .reg_wr  (reg_wr),
    .rx_valid(rx_valid),
    .done    (done),
    .err     (err),
    .err_code(err_code)
);

// File: tb/test_i2c_rand_read_seq.sv
module test_i2c_rand_read_seq;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 6;
    localparam int LIMIT      = 20;
    localparam int DLY        = 3;
    localparam logic [7:0] BAUD = 8'h24;
    localparam logic [6:0] DEV  = 7'h50;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ofs_wide = 1'b0;
    logic [6:0] tgt_addr = DEV;
    logic [15:0] ofs = '0;
    logic [7:0] count = '0;
    logic [7:0] eng_status = 8'hF8, eng_rdata = 8'h00;
    logic reg_wr, rx_valid, busy, done, err;
    logic [2:0] reg_sel;
    logic [7:0] reg_wdata, rx_data, err_code;

    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_rand_read_seq #(.GAP_CYCLES(GAP), .POLL_LIMIT(LIMIT), .CNT_W(8), .BAUD_VAL(BAUD)) i_i2c_rand_read_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr), .ofs(ofs),
        .ofs_wide(ofs_wide), .count(count), .eng_status(eng_status), .eng_rdata(eng_rdata),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy), .done(done), .err(err), .err_code(err_code)
    );

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // engine and target model, updated on falling edges
    bit nack_dev = 0, stall_ofs = 0;
    bit started = 0, want_addr = 0, have_data = 0;
    logic [7:0] dbyte = 0, pend_st = 0, pend_rd = 0;
    logic [15:0] ptr = 0;
    int nofs = 0, pend = 0, wcount = 0, nwr_total = 0;
    logic [2:0] wsel [0:3];
    logic [7:0] wdat [0:3];
    logic [7:0] got [0:31];
    int n_rx = 0, n_done = 0, n_err = 0;

    always @(negedge clk) begin
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin eng_status = pend_st; eng_rdata = pend_rd; end
        end
        if (rx_valid) begin if (n_rx < 32) got[n_rx] = rx_data; n_rx++; end
        if (done) n_done++;
        if (err) n_err++;
        if (reg_wr) begin
            nwr_total++;
            if (wcount < 4) begin wsel[wcount] = reg_sel; wdat[wcount] = reg_wdata; end
            wcount++;
            if (reg_sel == 3'd5) begin dbyte = reg_wdata; have_data = 1; end
            else if (reg_sel == 3'd4) begin
                eng_status = 8'hF8;
                pend_rd = eng_rdata;
                pend = DLY;
                if (reg_wdata[5]) begin
                    pend_st = started ? 8'h10 : 8'h08; started = 1; want_addr = 1;
                end else if (reg_wdata[4]) begin
                    pend_st = 8'hF8; started = 0;
                end else if (have_data) begin
                    have_data = 0;
                    if (want_addr) begin
                        want_addr = 0; nofs = 0;
                        if (nack_dev || dbyte[7:1] != DEV) pend_st = dbyte[0] ? 8'h48 : 8'h20;
                        else pend_st = dbyte[0] ? 8'h40 : 8'h18;
                    end else if (stall_ofs) begin
                        pend = 0;
                    end else begin
                        ptr = (nofs == 0) ? {8'h00, dbyte} : {ptr[7:0], dbyte};
                        nofs++; pend_st = 8'h28;
                    end
                end else if (started) begin
                    pend_st = reg_wdata[2] ? 8'h50 : 8'h58;
                    pend_rd = mem(ptr); ptr = ptr + 1;
                end else pend_st = 8'hF8;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        wcount = 0; n_rx = 0; n_done = 0; n_err = 0; nwr_total = 0;
        started = 0; want_addr = 0; have_data = 0;
    endtask

    task automatic launch(input logic [15:0] o, input bit w, input logic [7:0] c);
        @(negedge clk);
        ofs = o; ofs_wide = w; count = c; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000 && n_done == 0 && n_err == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_bytes(input logic [15:0] base, input int c, input string req);
        for (int i = 0; i < c; i++)
            chk(got[i] == mem(base + 16'(i)), req, got[i], mem(base + 16'(i)));
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err && !rx_valid && !reg_wr, "R11", {busy,done,err,rx_valid,reg_wr}, 0);
    endtask

    task automatic t_narrow_multi();
        clear_log();
        launch(16'h0037, 0, 8'd3);
        repeat (4) @(negedge clk);
        start = 1; count = 0;                       // R10: zero-count request while busy
        @(negedge clk); start = 0;
        wait_end();
        chk(wsel[0] == 3'd0 && wdat[0] == 8'h00, "R1", {wsel[0], wdat[0]}, 0);
        chk(wsel[1] == 3'd1 && wdat[1] == 8'h00, "R1", {wsel[1], wdat[1]}, 16'h100);
        chk(wsel[2] == 3'd2 && wdat[2] == 8'h00, "R1", {wsel[2], wdat[2]}, 16'h200);
        chk(wsel[3] == 3'd3 && wdat[3] == BAUD, "R1", {wsel[3], wdat[3]}, {8'd3, BAUD});
        chk(n_done == 1 && n_err == 0, "R2 R4 R5", n_done, 1);
        chk(n_err == 0, "R10", n_err, 0);
        chk(n_rx == 3, "R6", n_rx, 3);
        check_bytes(16'h0037, 3, "R3 R6");
        chk(!busy, "R5", busy, 0);
    endtask

    task automatic t_wide_single();
        clear_log();
        launch(16'h12C4, 1, 8'd1);
        wait_end();
        chk(n_done == 1 && n_err == 0, "R3 R5", n_done, 1);
        chk(n_rx == 1, "R6", n_rx, 1);
        check_bytes(16'h12C4, 1, "R3");
    endtask

    task automatic t_wide_long();
        clear_log();
        launch(16'hA0FE, 1, 8'd5);
        wait_end();
        chk(n_done == 1 && n_rx == 5, "R5", n_rx, 5);
        check_bytes(16'hA0FE, 5, "R6");
    endtask

    task automatic t_zero();
        clear_log();
        @(negedge clk);
        count = 0; start = 1;
        @(negedge clk);
        start = 0;
        chk(err && err_code == 8'hFF, "R9", {err, err_code}, 16'h1FF);
        repeat (20) @(negedge clk);
        chk(nwr_total == 0 && !busy, "R9", nwr_total, 0);
    endtask

    task automatic t_nack();
        clear_log();
        nack_dev = 1;
        launch(16'h0010, 0, 8'd2);
        wait_end();
        nack_dev = 0;
        chk(n_err == 1 && n_done == 0, "R7", n_err, 1);
        chk(err_code == 8'h20, "R8", err_code, 8'h20);
        chk(n_rx == 0 && !busy, "R8", n_rx, 0);
    endtask

    task automatic t_stall();
        int t0, t1;
        clear_log();
        stall_ofs = 1;
        launch(16'h0300, 1, 8'd2);
        t0 = $time;
        wait_end();
        t1 = $time;
        stall_ofs = 0;
        chk(n_err == 1 && err_code == 8'hF8, "R8", err_code, 8'hF8);
        chk((t1 - t0) / CLK_PERIOD >= GAP * LIMIT, "R7", (t1 - t0) / CLK_PERIOD, GAP * LIMIT);
        chk(n_rx == 0, "R8", n_rx, 0);
        repeat (10) @(negedge clk);
        chk(err_code == 8'hF8, "R8", err_code, 8'hF8);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_narrow_multi();
        t_wide_single();
        t_wide_long();
        t_zero();
        t_nack();
        t_stall();
        t_narrow_multi();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule